// File: doc/BRIEF.md
# Gated Capture-Difference Frequency Counter

This block measures how many rising edges an unknown signal makes between two rising edges of a gate signal. The unknown signal drives a running count that is never cleared. On each gate edge the whole count is latched, and the block reports the difference between this latch and the one before it. The host divides that span by the known gate period to obtain a frequency. Keeping the count running means no edge is lost while a result is being handled.

The running count is built from equal-width halves chained by carry, and the halves together form one wide value. All halves are latched in the same clock cycle, so a carry from one half into the next can never split a capture. Both the unknown signal and the gate are synchronized into the local clock domain through matching pipelines. Because the two paths have the same delay, an unknown-signal edge and a gate edge that arrive together are ordered the same way inside the block as at its pins. A ready flag announces each new span and stays up until the host acknowledges it.

Top module: `gate_span_counter`

## Requirements
- R1: While reset is held low and on the first cycle after it, `span_out` is 0 and `ready_out` is 0.
- R2: After each gate edge other than the first, `span_out` equals the number of 0-to-1 transitions of `sig_in` that were seen after the previous gate edge and up to and including this one.
- R3: The running count is not cleared at gate edges and carries from one half into the next. A span whose edges cross a half boundary is reported exactly.
- R4: The span is computed modulo 2^(HALF_W*HALVES). When more edges than that arrive between two gates, the reported span is the edge count reduced by that modulus.
- R5: The first gate edge after reset only records the count and does not raise `ready_out`.
- R6: `ready_out` goes to 1 in the cycle after a capture and stays at 1, with `span_out` unchanged, until `ack_in` is sampled high.
- R7: A `sig_in` edge reaching the counter in the same cycle as a gate edge belongs to the span that ends at that gate edge. This also holds when that edge carries the low half into the high half.
- R8: `sig_in` held high for many cycles counts as one edge.
- R9: `ack_in` with no new capture clears `ready_out` one cycle later and leaves `span_out` unchanged.
- R10: When a capture and `ack_in` fall in the same cycle, the capture wins and `ready_out` stays at 1 with the new span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Unknown signal whose rising edges are counted (asynchronous) |
| gate_in | input | 1 | Gate signal; each rising edge ends one span (asynchronous) |
| ack_in | input | 1 | Host acknowledge; clears the ready flag |
| span_out | output | HALF_W*HALVES | Edges between the last two gate edges, modulo 2^(HALF_W*HALVES) |
| ready_out | output | 1 | A new span is waiting for the host |

## Verification
The bench builds the block with HALF_W=4 and HALVES=2, which gives an 8-bit running count. With that width a low-half carry occurs every 16 edges and a full wrap every 256 edges. A carry that lands exactly on a gate edge and a span longer than the modulus can therefore both be reached in a few hundred cycles. SYNC_STAGES keeps its default of 2, so the same capture timing applies as in a full-width build.

// File: rtl/gsc_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the gated span counter.
// Assumes: nothing beyond IEEE 1800-2017.
package gsc_pkg;

    // State of the previous-capture register.
    typedef enum logic {
        PRIME_EMPTY = 1'b0,  // no capture taken since reset
        PRIME_HELD  = 1'b1   // previous capture is valid
    } prime_e;

    // Smallest synchronizer depth that resolves metastability.
    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/gsc_edge_sync.sv
`timescale 1ns/1ps
// Module: gsc_edge_sync
// Brings an asynchronous level into the clk domain and flags each 0-to-1
// transition with a one-cycle pulse.
// Assumes: the input stays at each level for at least one clk period, so
// no transition falls between samples.
module gsc_edge_sync
    import gsc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);

    localparam int unsigned DEPTH = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [DEPTH-1:0] chain_q;
    logic             last_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], level_in};
        end
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain_q[DEPTH-1];
        end
    end

    // A rise is a synchronized high that was low one cycle before.
    always_comb begin
        rise_out = chain_q[DEPTH-1] & ~last_q;
    end

    // R8
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_out |=> !rise_out);

endmodule

// File: rtl/gsc_cascade.sv
`timescale 1ns/1ps
// Module: gsc_cascade
// Running counter made of HALVES equal halves of HALF_W bits each. A half
// advances when all halves below it are at their maximum and the count is
// incremented. It is never cleared outside reset. count_nx is the value
// that the count will take after this cycle, carry included, so a capture
// taken from it is always consistent across halves.
// Assumes: inc_in is a single-cycle pulse per counted event.
module gsc_cascade #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc_in,
    output logic [HALF_W*HALVES-1:0] count_nx
);

    localparam int unsigned W = HALF_W * HALVES;
    localparam logic [W-1:0] ONE_W = W'(1);

    logic [HALVES:0]   carry;
    logic [W-1:0]      count_q;

    // The lowest half is advanced by the increment itself.
    always_comb begin
        carry[0] = inc_in;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] half_q;
        logic [HALF_W-1:0] half_nx;

        // Next value of this half and carry into the one above.
        always_comb begin
            half_nx      = half_q + {{(HALF_W-1){1'b0}}, carry[h]};
            carry[h + 1] = carry[h] & (&half_q);
        end

        // Hold the half between events; clear only on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else begin
                half_q <= half_nx;
            end
        end

        // Place this half into the combined views.
        always_comb begin
            count_q[h*HALF_W +: HALF_W]  = half_q;
            count_nx[h*HALF_W +: HALF_W] = half_nx;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_in |=> (count_q == W'($past(count_q) + ONE_W)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_in |=> $stable(count_q));

endmodule

// File: rtl/gsc_capture.sv
`timescale 1ns/1ps
// Module: gsc_capture
// Latches the running count on each gate edge, takes the modulo difference
// against the previous latch, and handles the ready/acknowledge exchange.
// The first gate edge after reset only fills the previous-capture register.
// Assumes: value_in already includes any increment of the capture cycle.
module gsc_capture
    import gsc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic [W-1:0] value_in,
    input  logic         ack_in,
    output logic [W-1:0] span_out,
    output logic         ready_out
);

    prime_e       prime_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] diff;

    // Modulo-2^W distance from the previous capture.
    always_comb begin
        diff = value_in - prev_q;
    end

    // Record every capture as the base of the next span.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            prime_q <= PRIME_EMPTY;
        end else if (cap_in) begin
            prev_q  <= value_in;
            prime_q <= PRIME_HELD;
        end
    end

    // Publish a span once a previous capture exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_out <= '0;
        end else if (cap_in && (prime_q == PRIME_HELD)) begin
            span_out <= diff;
        end
    end

    // Ready is set by a published span and cleared by acknowledge; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_out <= 1'b0;
        end else if (cap_in && (prime_q == PRIME_HELD)) begin
            ready_out <= 1'b1;
        end else if (ack_in) begin
            ready_out <= 1'b0;
        end
    end

    // R5
    first_prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prime_q == PRIME_EMPTY) |=> !ready_out);

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_out && !ack_in && !cap_in) |=> (ready_out && $stable(span_out)));

    // R10
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_in && (prime_q == PRIME_HELD)) |=> ready_out);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !cap_in) |=> (!ready_out && $stable(span_out)));

endmodule

// File: rtl/gate_span_counter.sv
`timescale 1ns/1ps
// Module: gate_span_counter (top)
// Counts rising edges of sig_in in a running cascaded counter and reports
// the count between successive rising edges of gate_in.
// Assumes: sig_in and gate_in each hold every level for at least one clk
// period; the host divides span_out by the gate period.
module gate_span_counter #(
    parameter int unsigned HALF_W      = 16,
    parameter int unsigned HALVES      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sig_in,
    input  logic                     gate_in,
    input  logic                     ack_in,
    output logic [HALF_W*HALVES-1:0] span_out,
    output logic                     ready_out
);

    localparam int unsigned W = HALF_W * HALVES;

    logic         sig_rise;
    logic         gate_rise;
    logic [W-1:0] count_nx;

    // Equal-depth synchronizers keep sig and gate events in pin order.
    gsc_edge_sync #(.STAGES(SYNC_STAGES)) i_sig_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sig_in),
        .rise_out (sig_rise)
    );

    gsc_edge_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (gate_in),
        .rise_out (gate_rise)
    );

    gsc_cascade #(.HALF_W(HALF_W), .HALVES(HALVES)) i_cascade (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_in   (sig_rise),
        .count_nx (count_nx)
    );

    gsc_capture #(.W(W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (gate_rise),
        .value_in  (count_nx),
        .ack_in    (ack_in),
        .span_out  (span_out),
        .ready_out (ready_out)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!ready_out && (span_out == '0)));

endmodule

// File: tb/test_gate_span_counter.sv
`timescale 1ns/1ps
module test_gate_span_counter;

    localparam int unsigned HALF_W = 4;
    localparam int unsigned HALVES = 2;
    localparam int unsigned W      = HALF_W * HALVES;
    localparam int          MODV   = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sig_in;
    logic         gate_in;
    logic         ack_in;
    logic [W-1:0] span_out;
    logic         ready_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;
    bit auto_ack = 0;

    // Bench model state
    int edges_since = 0;
    int total_edges = 0;
    bit primed      = 0;
    logic sig_prev  = 1'b0;
    logic gate_prev = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    string cur_tag = "R2";

    always #2.5 clk = ~clk;

    gate_span_counter #(.HALF_W(HALF_W), .HALVES(HALVES), .SYNC_STAGES(2)) i_gate_span_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .gate_in   (gate_in),
        .ack_in    (ack_in),
        .span_out  (span_out),
        .ready_out (ready_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one negedge step; the model counts sig rises, gate rises push spans.
    task automatic step(input logic s, input logic g, input logic a);
        @(negedge clk);
        if (rst_n && s && !sig_prev) begin
            edges_since++;
            total_edges++;
        end
        if (rst_n && g && !gate_prev) begin
            if (primed) begin
                exp_q.push_back(edges_since % MODV);
                tag_q.push_back(cur_tag);
            end
            primed      = 1;
            edges_since = 0;
        end
        sig_prev  = s;
        gate_prev = g;
        sig_in    = s;
        gate_in   = g;
        if (!auto_ack) ack_in = a;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            repeat (hi) step(1, 0, 0);
            repeat (lo) step(0, 0, 0);
        end
    endtask

    task automatic gate_pulse();
        repeat (2) step(0, 1, 0);
        repeat (8) step(0, 0, 0);
    endtask

    // Pop one expected span and compare it with the output.
    task automatic pop_cmp(input string extra);
        int e;
        string t;
        if (exp_q.size() == 0) begin
            chk(0, {extra, " unexpected result"}, span_out, -1);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk((span_out == W'(e)) && ready_out, {t, " ", extra}, span_out, e);
        end
    endtask

    // Monitor: in automatic mode compare each new span and acknowledge it.
    always @(negedge clk) begin
        if (auto_ack && rst_n) begin
            if (ack_in) begin
                ack_in <= 1'b0;
            end else if (ready_out) begin
                pop_cmp("span");
                ack_in <= 1'b1;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        rst_n = 1'b0; sig_in = 1'b0; gate_in = 1'b0; ack_in = 1'b0;
        repeat (4) step(0, 0, 0);
        // R1: idle outputs during reset
        chk(!ready_out && span_out == 0, "R1 reset", span_out, 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0);
        chk(!ready_out && span_out == 0, "R1 after reset", ready_out, 0);

        // R5: first gate only primes
        cur_tag = "R5";
        pulses(3, 1, 1);
        gate_pulse();
        repeat (6) step(0, 0, 0);
        chk(!ready_out, "R5 no ready after first gate", ready_out, 0);
        chk(exp_q.size() == 0, "R5 nothing expected", exp_q.size(), 0);

        auto_ack = 1;
        // R2: assorted patterns
        cur_tag = "R2";
        pulses(5, 1, 1);  gate_pulse();
        pulses(12, 2, 3); gate_pulse();
        gate_pulse();                       // zero edges
        pulses(1, 1, 2);  gate_pulse();
        // R3: crosses the low-half boundary
        cur_tag = "R3";
        pulses(40, 1, 1); gate_pulse();
        pulses(17, 1, 2); gate_pulse();
        // R4: more edges than the modulus
        cur_tag = "R4";
        pulses(300, 1, 1); gate_pulse();
        // R8: long high level counts once
        cur_tag = "R8";
        repeat (40) step(1, 0, 0);
        step(0, 0, 0);
        gate_pulse();
        // R7: edge with low-half carry coinciding with gate edge
        cur_tag = "R7";
        while ((total_edges % (1 << HALF_W)) != (1 << HALF_W) - 1) pulses(1, 1, 1);
        pulses(2, 1, 1);
        while ((total_edges % (1 << HALF_W)) != (1 << HALF_W) - 1) pulses(1, 1, 1);
        step(1, 1, 0);
        step(1, 1, 0);
        repeat (8) step(0, 0, 0);
        repeat (6) step(0, 0, 0);
        auto_ack = 0;
        repeat (4) step(0, 0, 0);
        chk(exp_q.size() == 0 && !ready_out, "R2 all spans reported", exp_q.size(), 0);

        // R6: ready holds without acknowledge
        cur_tag = "R6";
        pulses(7, 1, 1);
        gate_pulse();
        pop_cmp("held");
        held = span_out;
        repeat (20) step(0, 0, 0);
        chk(ready_out && span_out == held, "R6 ready held", span_out, held);

        // R10: capture coincides with acknowledge
        cur_tag = "R10";
        pulses(3, 1, 1);
        step(0, 1, 0);
        step(0, 1, 0);
        step(0, 0, 1);
        step(0, 0, 0);
        pop_cmp("capture beats ack");

        // R9: acknowledge clears; extra acknowledge changes nothing
        step(0, 0, 1);
        step(0, 0, 0);
        chk(!ready_out, "R9 ack clears", ready_out, 0);
        held = span_out;
        step(0, 0, 1);
        step(0, 0, 0);
        chk(!ready_out && span_out == held, "R9 idle ack", span_out, held);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule